// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block is the 64-bit double shift stage of an integer execution pipeline. It moves a destination operand left or right by a count. The bit positions that the shift empties are refilled from a second source operand, so the two operands act as one 128-bit value and a 64-bit window is taken from it. Along with the shifted value, the block produces the carry, overflow, sign, zero, parity and auxiliary-carry flags.

The count comes from one of two 8-bit inputs: an immediate field or a count register. A select line, decoded from the opcode, picks which one is used. Only the low six bits of the chosen count take effect. A count that masks to zero is a no-op. The result and the flags are registered one cycle after an operation is accepted. A single write-enable pulse tells the register file and the flag register to take both together.

Top module: `fshd_unit`

## Requirements
- R1: Only the low 6 bits of the selected 8-bit count are used. For example, 0x47 acts as 7, 0xC1 acts as 1, and 0x40 acts as 0.
- R2: When `cnt_use_reg` = 0 the count is taken from `imm_cnt`. When `cnt_use_reg` = 1 it is taken from `reg_cnt`. The unselected input has no effect.
- R3: With `shift_right` = 0 (left), the result is dst shifted left by c, with the vacated low c bits filled from the top c bits of src.
- R4: With `shift_right` = 1 (right), the result is dst shifted right by c, with the vacated high c bits filled from the low c bits of src.
- R5: On a left shift, CF is dst bit (64 − c) and OF is CF XOR result bit 63.
- R6: On a right shift, CF is dst bit (c − 1) and OF is result bit 62 XOR result bit 63.
- R7: SF is result bit 63 and ZF is 1 exactly when the 64-bit result is zero. PF is 1 when result bits 7:0 hold an even number of ones.
- R8: AF is always written as 0.
- R9: An accepted operation whose masked count is zero leaves `wr_en` low, and the result and all flag outputs keep their previous values.
- R10: An accepted operation with a nonzero masked count raises `wr_en` for exactly one cycle, on the clock edge that follows acceptance, with the new result and flags. Without `op_valid`, `wr_en` stays low.
- R11: After reset, the result, all flags and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| shift_right | input | 1 | 0 = left double shift, 1 = right double shift |
| cnt_use_reg | input | 1 | 0 = count from immediate, 1 = count from count register |
| imm_cnt | input | 8 | Immediate count field |
| reg_cnt | input | 8 | Count register value |
| dst_in | input | 64 | Destination operand |
| src_in | input | 64 | Fill source operand |
| res_out | output | 64 | Registered shift result |
| cf_out | output | 1 | Carry flag |
| of_out | output | 1 | Overflow flag |
| sf_out | output | 1 | Sign flag |
| zf_out | output | 1 | Zero flag |
| pf_out | output | 1 | Parity flag |
| af_out | output | 1 | Auxiliary-carry flag |
| wr_en | output | 1 | Write strobe for both result and flags |

## Verification
The bench builds the block with its default 64-bit width and 8-bit count inputs. With those values it reaches both count boundaries, 1 and 63, in each direction, as well as the counts that mask to zero and wrap to small values. These are the cases where the carry bit moves to the opposite end of the destination and the overflow rule changes with direction. A reference model in the bench computes every bit one at a time from the requirement text. Results and flags are compared after each operation, along with the hold behaviour on zero counts.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic af;
  } fsh_flags_t;
endpackage

// File: rtl/fsh_count_pick.sv
module fsh_count_pick #(
  parameter int CNT_IN_W = 8,
  parameter int SHW      = 6
) (
  input  logic                cnt_use_reg,
  input  logic [CNT_IN_W-1:0] imm_cnt,
  input  logic [CNT_IN_W-1:0] reg_cnt,
  output logic [SHW-1:0]      cnt,
  output logic                cnt_zero
);
  logic [CNT_IN_W-1:0] raw;
  logic                unused_hi;

  // opcode-level selection of the count source
  assign raw       = cnt_use_reg ? reg_cnt : imm_cnt;
  assign cnt       = raw[SHW-1:0];
  assign unused_hi = ^raw[CNT_IN_W-1:SHW];
  assign cnt_zero  = (cnt == '0);
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
  parameter int W   = 64,
  parameter int SHW = 6
) (
  input  logic           shift_right,
  input  logic [SHW-1:0] cnt,
  input  logic [W-1:0]   dst,
  input  logic [W-1:0]   src,
  output logic [W-1:0]   res,
  output logic           cf,
  output logic           of
);
  logic [2*W:0] ext_l;
  logic [2*W:0] ext_r;
  logic         unused_bits;

  // one guard bit above (left) or below (right) catches the last bit shifted out
  assign ext_l = {1'b0, dst, src} << cnt;
  assign ext_r = {src, dst, 1'b0} >> cnt;
  assign unused_bits = ^ext_l[W-1:0] ^ (^ext_r[2*W:W+1]);

  always_comb begin
    if (shift_right) begin
      res = ext_r[W:1];
      cf  = ext_r[0];
      of  = res[W-1] ^ res[W-2];
    end else begin
      res = ext_l[2*W-1:W];
      cf  = ext_l[2*W];
      of  = cf ^ res[W-1];
    end
  end
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen #(
  parameter int W = 64
) (
  input  logic [W-1:0]       res,
  input  logic               cf,
  input  logic               of,
  output fsh_pkg::fsh_flags_t flags
);
  function automatic logic even_par8(input logic [7:0] b);
    return ~^b;
  endfunction

  always_comb begin
    flags.cf = cf;
    flags.of = of;
    flags.sf = res[W-1];
    flags.zf = (res == '0);
    flags.pf = even_par8(res[7:0]);
    flags.af = 1'b0;
  end
endmodule

// File: rtl/fshd_unit.sv
module fshd_unit #(
  parameter int W        = 64,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                shift_right,
  input  logic                cnt_use_reg,
  input  logic [CNT_IN_W-1:0] imm_cnt,
  input  logic [CNT_IN_W-1:0] reg_cnt,
  input  logic [W-1:0]        dst_in,
  input  logic [W-1:0]        src_in,
  output logic [W-1:0]        res_out,
  output logic                cf_out,
  output logic                of_out,
  output logic                sf_out,
  output logic                zf_out,
  output logic                pf_out,
  output logic                af_out,
  output logic                wr_en
);
  import fsh_pkg::*;
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] cnt;
  logic           cnt_zero;
  logic [W-1:0]   res_c;
  logic           cf_c, of_c;
  fsh_flags_t     flags_c, flags_q;
  logic           commit;

  fsh_count_pick #(.CNT_IN_W(CNT_IN_W), .SHW(SHW)) u_pick (
    .cnt_use_reg(cnt_use_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
    .cnt(cnt), .cnt_zero(cnt_zero));

  fsh_funnel #(.W(W), .SHW(SHW)) u_funnel (
    .shift_right(shift_right), .cnt(cnt), .dst(dst_in), .src(src_in),
    .res(res_c), .cf(cf_c), .of(of_c));

  fsh_flag_gen #(.W(W)) u_flags (
    .res(res_c), .cf(cf_c), .of(of_c), .flags(flags_c));

  assign commit = op_valid && !cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out <= '0;
      flags_q <= '0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= commit;
      if (commit) begin
        res_out <= res_c;
        flags_q <= flags_c;
      end
    end
  end

  assign cf_out = flags_q.cf;
  assign of_out = flags_q.of;
  assign sf_out = flags_q.sf;
  assign zf_out = flags_q.zf;
  assign pf_out = flags_q.pf;
  assign af_out = flags_q.af;

  // R9: zero masked count writes nothing and holds state
  a_r9_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cnt_zero |=> !wr_en && $stable(res_out) && $stable(flags_q));
  // R10: a write strobe always stems from an accepted operation
  a_r10_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(op_valid));
  // R8: auxiliary carry never set
  a_r8_af_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !af_out);
  // R7: zero flag agrees with registered result
  a_r7_zf_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> zf_out == (res_out == '0));
  // R5: left overflow rule
  a_r5_left_of: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !$past(shift_right) |-> of_out == (cf_out ^ res_out[W-1]));
  // R6: right overflow rule
  a_r6_right_of: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(shift_right) |-> of_out == (res_out[W-1] ^ res_out[W-2]));
endmodule

// File: tb/fshd_unit_tb.sv
`timescale 1ns/1ps
module fshd_unit_tb;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, shift_right = 1'b0, cnt_use_reg = 1'b0;
  logic [7:0] imm_cnt = '0, reg_cnt = '0;
  logic [W-1:0] dst_in = '0, src_in = '0;
  logic [W-1:0] res_out;
  logic cf_out, of_out, sf_out, zf_out, pf_out, af_out, wr_en;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fshd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .shift_right(shift_right),
    .cnt_use_reg(cnt_use_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
    .dst_in(dst_in), .src_in(src_in), .res_out(res_out), .cf_out(cf_out),
    .of_out(of_out), .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out),
    .af_out(af_out), .wr_en(wr_en));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bit-by-bit reference for the window taken from the paired operands
  function automatic logic [W-1:0] model(input logic rt, input logic [W-1:0] d,
                                         input logic [W-1:0] s, input int c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (!rt) r[i] = (i >= c) ? d[i-c] : s[W-c+i];
      else     r[i] = (i + c < W) ? d[i+c] : s[i+c-W];
    end
    return r;
  endfunction

  task automatic do_shift(input string tag, input logic rt, input logic sel,
                          input logic [7:0] im, input logic [7:0] rg,
                          input logic [W-1:0] d, input logic [W-1:0] s);
    int c;
    logic [W-1:0] er;
    logic ecf, eof;
    int ones;
    c = (sel ? int'(rg) : int'(im)) % 64;
    er = model(rt, d, s, c);
    if (!rt) begin ecf = d[W-c]; eof = ecf ^ er[W-1]; end
    else     begin ecf = d[c-1]; eof = er[W-1] ^ er[W-2]; end
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(er[k]);
    @(negedge clk);
    op_valid = 1'b1; shift_right = rt; cnt_use_reg = sel;
    imm_cnt = im; reg_cnt = rg; dst_in = d; src_in = s;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " R10 wr_en"}, W'(wr_en), W'(1));
    chk({tag, rt ? " R4 result" : " R3 result"}, res_out, er);
    chk({tag, rt ? " R6 cf" : " R5 cf"}, W'(cf_out), W'(ecf));
    chk({tag, rt ? " R6 of" : " R5 of"}, W'(of_out), W'(eof));
    chk({tag, " R7 sf"}, W'(sf_out), W'(er[W-1]));
    chk({tag, " R7 zf"}, W'(zf_out), W'(er == '0));
    chk({tag, " R7 pf"}, W'(pf_out), W'((ones % 2) == 0));
    chk({tag, " R8 af"}, W'(af_out), W'(0));
    @(negedge clk);
    chk({tag, " R10 one-cycle strobe"}, W'(wr_en), W'(0));
  endtask

  task automatic do_zero(input string tag, input logic sel,
                         input logic [7:0] im, input logic [7:0] rg);
    logic [W-1:0] pr;
    logic [5:0] pf;
    pr = res_out;
    pf = {cf_out, of_out, sf_out, zf_out, pf_out, af_out};
    @(negedge clk);
    op_valid = 1'b1; shift_right = 1'b0; cnt_use_reg = sel;
    imm_cnt = im; reg_cnt = rg; dst_in = ~res_out; src_in = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " R9 wr_en low"}, W'(wr_en), W'(0));
    chk({tag, " R9 result held"}, res_out, pr);
    chk({tag, " R9 flags held"}, W'({cf_out, of_out, sf_out, zf_out, pf_out, af_out}), W'(pf));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset result", res_out, '0);
    chk("R11 reset flags", W'({cf_out, of_out, sf_out, zf_out, pf_out, af_out}), W'(0));
    chk("R11 reset wr_en", W'(wr_en), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle no strobe", W'(wr_en), W'(0));

    do_shift("left c4", 1'b0, 1'b0, 8'd4, 8'd0, 64'h0123_4567_89AB_CDEF, 64'hF000_0000_0000_0000);
    do_shift("left c1 of", 1'b0, 1'b0, 8'd1, 8'd0, 64'h4000_0000_0000_0000, 64'h0);
    do_shift("left c63", 1'b0, 1'b0, 8'd63, 8'd0, 64'h0000_0000_0000_0003, 64'hAAAA_5555_AAAA_5555);
    do_shift("right c1", 1'b1, 1'b0, 8'd1, 8'd0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001);
    do_shift("right c8", 1'b1, 1'b0, 8'd8, 8'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_00A5);
    do_shift("right c63", 1'b1, 1'b0, 8'd63, 8'd0, 64'hC000_0000_0000_0000, 64'h1234_5678_9ABC_DEF1);
    do_shift("R2 reg sel", 1'b0, 1'b1, 8'd5, 8'd12, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F);
    do_shift("R2 imm sel", 1'b1, 1'b0, 8'd5, 8'd12, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F);
    do_shift("R1 mask 0x47", 1'b1, 1'b1, 8'd0, 8'h47, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    do_shift("R1 mask 0xC1", 1'b0, 1'b0, 8'hC1, 8'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    do_shift("R7 zero result", 1'b0, 1'b0, 8'd5, 8'd0, 64'h0, 64'h0);
    do_shift("R7 odd parity", 1'b1, 1'b0, 8'd4, 8'd0, 64'h0000_0000_0000_0070, 64'h0);
    do_zero("R1 imm 0x40", 1'b0, 8'h40, 8'd9);
    do_zero("R2 reg zero", 1'b1, 8'd9, 8'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule